// File: doc/BRIEF.md
# IPv4 Header Check and Strip Stage

This stage sits on a 32-bit word stream that carries IPv4 datagrams, one datagram per start/end delimited burst, with the first byte of each word in bits 31:24. It walks the header, captures the protocol number and both addresses onto sideband outputs, and confirms the header checksum. It lowers the time-to-live by one and supplies the matching checksum, which it derives from the stored checksum without summing the header a second time.

Once the header has been judged, the stage forwards only the payload words, one cycle behind the input. Each payload word carries a word offset, a first-word marker and, on the closing word, the byte enables that arrived with it. A datagram whose header fails any check is reported through the sideband flags, and none of its payload words leave the stage. The input has no backpressure, so the stage accepts one word on every clock for datagrams of any length.

Top module: `ipv4_hdr_wrap`

## Requirements
- R1: One cycle after the last header word, `hdr_done` pulses for one cycle. From then until the next pulse, `hdr_proto` holds word 2 bits 23:16, `hdr_src` holds word 3 and `hdr_dst` holds word 4 of that header.
- R2: The stage adds the header's 16-bit halves with end-around carry. If the result is anything other than 0xFFFF, it raises `err_csum` and clears `hdr_ok`.
- R3: For a header that passes, `hdr_ttl` equals the arriving time-to-live (word 2 bits 31:24) minus one. `hdr_csum` equals the checksum that would be computed from scratch over the header with that lowered time-to-live.
- R4: A header whose time-to-live is 0 or 1 raises `err_ttl` and clears `hdr_ok`. A time-to-live of 2 passes and gives `hdr_ttl` = 1.
- R5: A header whose version field (word 0 bits 31:28) is not 4, or whose length field (word 0 bits 27:24) is below 5, raises `err_fmt` and clears `hdr_ok`. In that case the header is taken as five words long.
- R6: The header length in words is read from word 0 bits 27:24. Option words up to that count are included in the checksum and are never forwarded, so the payload begins at that word index.
- R7: Payload words leave one cycle after they arrive. The first word has `out_first` = 1 and `out_offset` = 0, and the offset rises by one per forwarded word. The closing word has `out_last` = 1 and carries the input byte enable (bit 3 = bits 31:24). Every other word has `out_be` = 4'hF. After reset, `out_valid`, `hdr_done` and `hdr_ok` are 0.
- R8: When a header fails any check, `out_valid` stays low for every word of that datagram. The datagram that follows is judged on its own.
- R9: A datagram that ends before its header is complete produces `hdr_done` with `err_fmt` = 1. A datagram that ends on its last header word passes its checks and forwards no payload.
- R10: Datagrams of ten words (40 bytes) and of 375 words (1500 bytes) can arrive back to back with no idle cycle between them. Every one is judged and forwarded.
- R11: Cycles with `in_valid` low, whether inside the header or inside the payload, change neither the result nor the forwarded words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word, first byte in bits 31:24 |
| in_sop | input | 1 | First word of a datagram |
| in_eop | input | 1 | Last word of a datagram |
| in_be | input | 4 | Byte enables of the last word |
| out_valid | output | 1 | Payload word present |
| out_data | output | 32 | Payload word |
| out_first | output | 1 | First payload word |
| out_last | output | 1 | Last payload word |
| out_be | output | 4 | Byte enables, 4'hF except on the last word |
| out_offset | output | OFF_W | Payload word index, saturating |
| hdr_done | output | 1 | Header verdict pulse |
| hdr_ok | output | 1 | Header passed all checks (held) |
| err_csum | output | 1 | Checksum mismatch (held) |
| err_ttl | output | 1 | Time-to-live expired (held) |
| err_fmt | output | 1 | Bad version, short length field or truncated header (held) |
| hdr_proto | output | 8 | Protocol number |
| hdr_src | output | 32 | Source address |
| hdr_dst | output | 32 | Destination address |
| hdr_ttl | output | 8 | Lowered time-to-live |
| hdr_csum | output | 16 | Checksum patched for the lowered time-to-live |

## Verification
The assertions check the following on every cycle:
- a forwarded word only ever appears while the held verdict is a pass;
- non-final payload words carry full byte enables;
- the first payload word has offset zero;
- the header and payload phases never overlap;
- the header word index stays below the header length;
- a passing verdict never reports a zero time-to-live.

Some behaviours only the directed scenarios can show, because each needs a datagram built and checked end to end:
- whether the patched checksum equals a checksum recomputed from scratch;
- whether options shift the payload start by the right amount;
- whether corrupted, expired, malformed or truncated headers are each flagged by the right bit;
- whether back-to-back traffic of minimum and maximum length, with a failing datagram in the middle, keeps every packet boundary.

// File: rtl/ipv4p_pkg.sv
package ipv4p_pkg;

  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;
  localparam int HIDX_W = 4;

  localparam logic [3:0] IPV4_VERSION = 4'd4;
  localparam logic [3:0] IHL_MIN      = 4'd5;

  typedef struct packed {
    logic fmt;
    logic ttl;
    logic csum;
  } hdr_err_t;

  // ones-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // fold both halves of a 32-bit word
  function automatic logic [15:0] fold32(input logic [31:0] w);
    return oc_add16(w[31:16], w[15:0]);
  endfunction

  // incremental checksum update when one 16-bit field changes old_f -> new_f
  function automatic logic [15:0] csum_patch(input logic [15:0] csum,
                                             input logic [15:0] old_f,
                                             input logic [15:0] new_f);
    return ~oc_add16(oc_add16(~csum, ~old_f), new_f);
  endfunction

  // header length in words, clamped to the minimum legal header
  function automatic logic [3:0] hdr_words(input logic [3:0] ihl);
    return (ihl < IHL_MIN) ? IHL_MIN : ihl;
  endfunction

endpackage

// File: rtl/ipv4p_track.sv
module ipv4p_track
  import ipv4p_pkg::*;
#(
  parameter int OFF_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [3:0]          ihl_in,
  output logic                is_hdr,
  output logic [HIDX_W-1:0]   hdr_idx,
  output logic                hdr_last,
  output logic                hdr_trunc,
  output logic                is_pay,
  output logic                pay_first,
  output logic [OFF_W-1:0]    pay_off
);

  localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};

  logic              hdr_q, pay_q;
  logic [HIDX_W-1:0] idx_q;
  logic [3:0]        len_q;
  logic [OFF_W-1:0]  off_q;
  logic [3:0]        len_now;

  assign len_now   = in_sop ? hdr_words(ihl_in) : len_q;
  assign is_hdr    = in_valid & (in_sop | hdr_q);
  assign hdr_idx   = in_sop ? '0 : idx_q;
  assign hdr_last  = is_hdr & (hdr_idx == len_now - 4'd1);
  assign hdr_trunc = is_hdr & in_eop & ~hdr_last;
  assign is_pay    = in_valid & ~in_sop & pay_q;
  assign pay_first = is_pay & (off_q == '0);
  assign pay_off   = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= 1'b0;
      pay_q <= 1'b0;
      idx_q <= '0;
      len_q <= IHL_MIN;
      off_q <= '0;
    end else if (in_valid) begin
      if (is_hdr) begin
        if (in_sop) len_q <= len_now;
        if (hdr_last || in_eop) begin
          hdr_q <= 1'b0;
          pay_q <= hdr_last & ~in_eop;
          off_q <= '0;
        end else begin
          hdr_q <= 1'b1;
          pay_q <= 1'b0;
          idx_q <= hdr_idx + 1'b1;
        end
      end else if (is_pay) begin
        if (in_eop) pay_q <= 1'b0;
        else if (off_q != OFF_MAX) off_q <= off_q + 1'b1;
      end
    end
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_q && pay_q)); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_q |-> (idx_q < len_q)); // R6

endmodule

// File: rtl/ipv4p_csum.sv
module ipv4p_csum
  import ipv4p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_hdr,
  input  logic              in_sop,
  input  logic [WORD_W-1:0] in_data,
  output logic              sum_ok
);

  logic [15:0] acc_q, acc_cur;

  assign acc_cur = oc_add16(in_sop ? 16'h0000 : acc_q, fold32(in_data));
  assign sum_ok  = (acc_cur == 16'hFFFF);

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= 16'h0000;
    else if (is_hdr) acc_q <= acc_cur;
  end

endmodule

// File: rtl/ipv4p_fields.sv
module ipv4p_fields
  import ipv4p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_hdr,
  input  logic [HIDX_W-1:0] hdr_idx,
  input  logic              hdr_last,
  input  logic              hdr_trunc,
  input  logic              sum_ok,
  input  logic [WORD_W-1:0] in_data,
  output logic              hdr_done_o,
  output logic              hdr_ok_o,
  output hdr_err_t          err_o,
  output logic [7:0]        proto_o,
  output logic [31:0]       src_o,
  output logic [31:0]       dst_o,
  output logic [7:0]        ttl_o,
  output logic [15:0]       csum_o
);

  logic [3:0]  ver_q, ihl_q;
  logic [7:0]  ttl_q, proto_q;
  logic [15:0] csum_q;
  logic [31:0] src_q, dst_q;

  hdr_err_t    err_now;
  logic [31:0] dst_now;
  logic [7:0]  ttl_dec;
  logic        ttl_expired;

  assign ttl_expired  = (ttl_q <= 8'd1);
  assign ttl_dec      = ttl_q - 8'd1;
  assign dst_now      = (hdr_idx == HIDX_W'(4)) ? in_data : dst_q;
  assign err_now.fmt  = (ver_q != IPV4_VERSION) | (ihl_q < IHL_MIN);
  assign err_now.ttl  = ttl_expired;
  assign err_now.csum = ~sum_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q <= '0; ihl_q <= '0; ttl_q <= '0; proto_q <= '0;
      csum_q <= '0; src_q <= '0; dst_q <= '0;
    end else if (is_hdr) begin
      case (hdr_idx)
        HIDX_W'(0): begin ver_q <= in_data[31:28]; ihl_q <= in_data[27:24]; end
        HIDX_W'(2): begin ttl_q <= in_data[31:24]; proto_q <= in_data[23:16];
                          csum_q <= in_data[15:0]; end
        HIDX_W'(3): src_q <= in_data;
        HIDX_W'(4): dst_q <= in_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_done_o <= 1'b0;
      hdr_ok_o   <= 1'b0;
      err_o      <= '0;
      proto_o    <= '0;
      src_o      <= '0;
      dst_o      <= '0;
      ttl_o      <= '0;
      csum_o     <= '0;
    end else begin
      hdr_done_o <= hdr_last | hdr_trunc;
      if (hdr_last) begin
        err_o    <= err_now;
        hdr_ok_o <= ~(err_now.fmt | err_now.ttl | err_now.csum);
        proto_o  <= proto_q;
        src_o    <= src_q;
        dst_o    <= dst_now;
        ttl_o    <= ttl_dec;
        csum_o   <= csum_patch(csum_q, {ttl_q, proto_q}, {ttl_dec, proto_q});
      end else if (hdr_trunc) begin
        err_o    <= '{fmt: 1'b1, ttl: 1'b0, csum: 1'b0};
        hdr_ok_o <= 1'b0;
      end
    end
  end

  AST_TTL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done_o && hdr_ok_o) |-> (ttl_o != 8'd0)); // R4

endmodule

// File: rtl/ipv4_hdr_wrap.sv
module ipv4_hdr_wrap
  import ipv4p_pkg::*;
#(
  parameter int OFF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [3:0]       in_be,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_first,
  output logic             out_last,
  output logic [3:0]       out_be,
  output logic [OFF_W-1:0] out_offset,
  output logic             hdr_done,
  output logic             hdr_ok,
  output logic             err_csum,
  output logic             err_ttl,
  output logic             err_fmt,
  output logic [7:0]       hdr_proto,
  output logic [31:0]      hdr_src,
  output logic [31:0]      hdr_dst,
  output logic [7:0]       hdr_ttl,
  output logic [15:0]      hdr_csum
);

  logic              is_hdr, hdr_last, hdr_trunc, is_pay, pay_first, sum_ok;
  logic [HIDX_W-1:0] hdr_idx;
  logic [OFF_W-1:0]  pay_off;
  hdr_err_t          err;

  ipv4p_track #(.OFF_W(OFF_W)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .ihl_in(in_data[27:24]), .is_hdr(is_hdr),
    .hdr_idx(hdr_idx), .hdr_last(hdr_last), .hdr_trunc(hdr_trunc),
    .is_pay(is_pay), .pay_first(pay_first), .pay_off(pay_off)
  );

  ipv4p_csum u_csum (
    .clk(clk), .rst_n(rst_n), .is_hdr(is_hdr), .in_sop(in_sop),
    .in_data(in_data), .sum_ok(sum_ok)
  );

  ipv4p_fields u_fields (
    .clk(clk), .rst_n(rst_n), .is_hdr(is_hdr), .hdr_idx(hdr_idx),
    .hdr_last(hdr_last), .hdr_trunc(hdr_trunc), .sum_ok(sum_ok),
    .in_data(in_data), .hdr_done_o(hdr_done), .hdr_ok_o(hdr_ok),
    .err_o(err), .proto_o(hdr_proto), .src_o(hdr_src), .dst_o(hdr_dst),
    .ttl_o(hdr_ttl), .csum_o(hdr_csum)
  );

  assign err_csum = err.csum;
  assign err_ttl  = err.ttl;
  assign err_fmt  = err.fmt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      out_be     <= '0;
      out_offset <= '0;
    end else begin
      out_valid  <= is_pay & hdr_ok;
      out_data   <= in_data;
      out_first  <= pay_first;
      out_last   <= in_eop;
      out_be     <= in_eop ? in_be : {BE_W{1'b1}};
      out_offset <= pay_off;
    end
  end

  AST_DROP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hdr_ok); // R8
  AST_BE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_be == 4'hF)); // R7
  AST_FIRST_OFF0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> (out_offset == '0)); // R7

endmodule

// File: tb/ipv4_hdr_wrap_bench.sv
module ipv4_hdr_wrap_bench;

  localparam int OFF_W = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be = '0;
  logic out_valid, out_first, out_last, hdr_done, hdr_ok, err_csum, err_ttl, err_fmt;
  logic [31:0] out_data, hdr_src, hdr_dst;
  logic [3:0]  out_be;
  logic [OFF_W-1:0] out_offset;
  logic [7:0]  hdr_proto, hdr_ttl;
  logic [15:0] hdr_csum;

  always #10 clk = ~clk;

  ipv4_hdr_wrap #(.OFF_W(OFF_W)) u_ipv4_hdr_wrap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_be(in_be), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .out_be(out_be), .out_offset(out_offset), .hdr_done(hdr_done),
    .hdr_ok(hdr_ok), .err_csum(err_csum), .err_ttl(err_ttl), .err_fmt(err_fmt),
    .hdr_proto(hdr_proto), .hdr_src(hdr_src), .hdr_dst(hdr_dst),
    .hdr_ttl(hdr_ttl), .hdr_csum(hdr_csum)
  );

  int nchk = 0, nbad = 0;

  // datagram under construction
  logic [31:0] pk [0:511];
  int pk_len, hlen;
  logic [15:0] exp_csum;

  // expected payload
  logic [46:0] exp_w [0:1023];
  int exp_n;

  // observed
  logic [46:0] pay_w [0:1023];
  int pay_cnt;
  logic [3:0]  dn_flags [0:15];
  logic [7:0]  dn_proto [0:15];
  logic [31:0] dn_src [0:15], dn_dst [0:15];
  logic [7:0]  dn_ttl [0:15];
  logic [15:0] dn_csum [0:15];
  int dn_cnt;

  always @(negedge clk) begin
    if (hdr_done && dn_cnt < 16) begin
      dn_flags[dn_cnt] = {hdr_ok, err_csum, err_ttl, err_fmt};
      dn_proto[dn_cnt] = hdr_proto;
      dn_src[dn_cnt]   = hdr_src;
      dn_dst[dn_cnt]   = hdr_dst;
      dn_ttl[dn_cnt]   = hdr_ttl;
      dn_csum[dn_cnt]  = hdr_csum;
      dn_cnt++;
    end
    if (out_valid && pay_cnt < 1024) begin
      pay_w[pay_cnt] = {out_first, out_last, out_be, out_offset, out_data};
      pay_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bsum(input int n);
    int unsigned s = 0;
    for (int i = 0; i < n; i++) s += pk[i][31:16] + pk[i][15:0];
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic build(input logic [3:0] ver, input logic [3:0] ihl, input logic [7:0] ttl,
                       input logic [7:0] proto, input logic [31:0] src, input logic [31:0] dst,
                       input int npay, input bit bad, input int seed);
    hlen   = (ihl < 5) ? 5 : int'(ihl);
    pk_len = hlen + npay;
    pk[0] = {ver, ihl, 8'h00, 16'(pk_len * 4)};
    pk[1] = {16'(16'h1234 + seed), 16'h4000};
    pk[2] = {ttl - 8'd1, proto, 16'h0000};
    pk[3] = src;
    pk[4] = dst;
    for (int i = 5; i < hlen; i++) pk[i] = {8'hA5, 8'(i), 16'(seed)};
    exp_csum = bsum(hlen);
    pk[2] = {ttl, proto, 16'h0000};
    pk[2][15:0] = bsum(hlen) ^ (bad ? 16'h0400 : 16'h0000);
    for (int i = 0; i < npay; i++) pk[hlen + i] = {8'(seed), 8'h5A, 16'(i * 3 + 1)};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    end
  endtask

  task automatic send(input bit pass, input logic [3:0] last_be, input bit gaps);
    for (int w = 0; w < pk_len; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pk[w];
      in_sop   = (w == 0);
      in_eop   = (w == pk_len - 1);
      in_be    = (w == pk_len - 1) ? last_be : 4'h0;
      if (pass && w >= hlen) begin
        exp_w[exp_n] = {(w == hlen), (w == pk_len - 1),
                        (w == pk_len - 1) ? last_be : 4'hF, OFF_W'(w - hlen), pk[w]};
        exp_n++;
      end
      if (gaps && (w % 3 == 1)) idle(2);
    end
  endtask

  task automatic clear();
    exp_n = 0; pay_cnt = 0; dn_cnt = 0;
  endtask

  task automatic check_pay(input string req);
    chk(pay_cnt == exp_n, req, "payload count", 64'(pay_cnt), 64'(exp_n));
    for (int i = 0; i < exp_n && i < pay_cnt; i++)
      chk(pay_w[i] == exp_w[i], req, "payload word", 64'(pay_w[i]), 64'(exp_w[i]));
  endtask

  // flags = {ok, csum, ttl, fmt}
  task automatic check_flags(input int i, input string req, input logic [3:0] exp);
    chk(dn_cnt > i, req, "verdict count", 64'(dn_cnt), 64'(i + 1));
    if (dn_cnt > i) chk(dn_flags[i] == exp, req, "verdict flags", 64'(dn_flags[i]), 64'(exp));
  endtask

  task automatic t_reset();
    chk(!out_valid && !hdr_done && !hdr_ok, "R7", "reset outputs",
        64'({out_valid, hdr_done, hdr_ok}), 64'(0));
  endtask

  task automatic t_basic();
    clear();
    build(4, 5, 8'd64, 8'd6, 32'h0A00_0001, 32'hC0A8_0102, 4, 0, 1);
    send(1, 4'b1100, 0);
    idle(4);
    check_flags(0, "R1", 4'b1000);
    chk(dn_proto[0] == 8'd6, "R1", "protocol", 64'(dn_proto[0]), 64'(6));
    chk(dn_src[0] == 32'h0A00_0001, "R1", "source", 64'(dn_src[0]), 64'h0A00_0001);
    chk(dn_dst[0] == 32'hC0A8_0102, "R1", "destination", 64'(dn_dst[0]), 64'hC0A8_0102);
    chk(dn_ttl[0] == 8'd63, "R3", "lowered ttl", 64'(dn_ttl[0]), 64'(63));
    chk(dn_csum[0] == exp_csum, "R3", "patched checksum", 64'(dn_csum[0]), 64'(exp_csum));
    chk(hdr_proto == 8'd6, "R1", "protocol held", 64'(hdr_proto), 64'(6));
    check_pay("R7");
  endtask

  task automatic t_options();
    clear();
    build(4, 7, 8'd32, 8'd17, 32'h0102_0304, 32'h0506_0708, 3, 0, 2);
    send(1, 4'b1000, 0);
    idle(4);
    check_flags(0, "R6", 4'b1000);
    chk(dn_csum[0] == exp_csum, "R6", "checksum with options", 64'(dn_csum[0]), 64'(exp_csum));
    chk(dn_dst[0] == 32'h0506_0708, "R6", "destination", 64'(dn_dst[0]), 64'h0506_0708);
    check_pay("R6");
  endtask

  task automatic t_badsum();
    clear();
    build(4, 5, 8'd40, 8'd6, 32'h1111_2222, 32'h3333_4444, 5, 1, 3);
    send(0, 4'hF, 0);
    idle(4);
    check_flags(0, "R2", 4'b0100);
    chk(pay_cnt == 0, "R8", "no payload on bad checksum", 64'(pay_cnt), 64'(0));
  endtask

  task automatic t_ttl();
    clear();
    build(4, 5, 8'd1, 8'd6, 32'h1, 32'h2, 3, 0, 4);
    send(0, 4'hF, 0);
    build(4, 5, 8'd0, 8'd6, 32'h1, 32'h2, 3, 0, 5);
    send(0, 4'hF, 0);
    build(4, 5, 8'd2, 8'd6, 32'h1, 32'h2, 3, 0, 6);
    send(1, 4'hF, 0);
    idle(4);
    check_flags(0, "R4", 4'b0010);
    check_flags(1, "R4", 4'b0010);
    check_flags(2, "R4", 4'b1000);
    chk(dn_ttl[2] == 8'd1, "R4", "ttl 2 lowered", 64'(dn_ttl[2]), 64'(1));
    chk(dn_csum[2] == exp_csum, "R3", "checksum at ttl 2", 64'(dn_csum[2]), 64'(exp_csum));
    check_pay("R8");
  endtask

  task automatic t_fmt();
    clear();
    build(6, 5, 8'd9, 8'd6, 32'h7, 32'h8, 2, 0, 7);
    send(0, 4'hF, 0);
    build(4, 4, 8'd9, 8'd6, 32'h7, 32'h8, 2, 0, 8);
    send(0, 4'hF, 0);
    idle(4);
    check_flags(0, "R5", 4'b0001);
    check_flags(1, "R5", 4'b0001);
    chk(pay_cnt == 0, "R5", "no payload on bad format", 64'(pay_cnt), 64'(0));
  endtask

  task automatic t_short();
    clear();
    build(4, 5, 8'd9, 8'd6, 32'h7, 32'h8, 0, 0, 9);
    pk_len = 3;
    send(0, 4'hF, 0);
    idle(3);
    build(4, 5, 8'd9, 8'd6, 32'h7, 32'h8, 0, 0, 10);
    send(0, 4'hF, 0);
    idle(4);
    check_flags(0, "R9", 4'b0001);
    check_flags(1, "R9", 4'b1000);
    chk(pay_cnt == 0, "R9", "header-only payload", 64'(pay_cnt), 64'(0));
  endtask

  task automatic t_b2b();
    clear();
    for (int p = 0; p < 6; p++) begin
      build(4, 5, 8'd20, 8'(p), 32'h0A00_0000 + p, 32'h0B00_0000 + p, 5, (p == 3), 16 + p);
      send(p != 3, 4'hF, 0);
    end
    build(4, 5, 8'd128, 8'd6, 32'hAA, 32'hBB, 370, 0, 30);
    send(1, 4'b1110, 0);
    idle(4);
    chk(dn_cnt == 7, "R10", "verdicts", 64'(dn_cnt), 64'(7));
    for (int p = 0; p < 7; p++)
      check_flags(p, "R10", (p == 3) ? 4'b0100 : 4'b1000);
    chk(dn_proto[5] == 8'd5, "R10", "protocol of 6th", 64'(dn_proto[5]), 64'(5));
    check_pay("R10");
  endtask

  task automatic t_gaps();
    clear();
    build(4, 6, 8'd77, 8'd1, 32'hC000_0001, 32'hC000_0002, 6, 0, 40);
    send(1, 4'b1100, 1);
    idle(4);
    check_flags(0, "R11", 4'b1000);
    chk(dn_csum[0] == exp_csum, "R11", "checksum with gaps", 64'(dn_csum[0]), 64'(exp_csum));
    check_pay("R11");
  endtask

  initial begin
    #(20 * 100000);
    nbad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_options();
    t_badsum();
    t_ttl();
    t_fmt();
    t_short();
    t_b2b();
    t_gaps();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule